// File: doc/BRIEF.md
# Wait Condition Release Evaluator

This block decides, tick by tick, when a suspended process may resume. It watches two multi-bit input buses and flags a change on a bus whenever its value at the current tick differs from its value at the previous tick. A change on either bus that coincides with a true guard input is a start condition, and it releases the process at once. When no start condition arrives, a restartable tick counter releases the process after a programmable number of ticks. The output is a single-cycle pulse per releasing tick.

The block runs on the system clock. The tick-enable input marks the clock cycles that count as time steps. On every other cycle the block holds its state and does not release. Reset counts as a start condition, so the timeout window opens at reset. A timeout value of zero switches the timeout path off. The scheduler that acts on the pulse is outside this block.

Top module: `wait_release_eval`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it, `release_o` is 0. The previous-value registers load the current bus values during reset, so an unchanged bus at the first tick after reset gives no change event.
- R2: At a tick where `watch_a` differs from its value at the previous tick and `guard` is 1, `release_o` is 1 in the following clock cycle.
- R3: At a tick where `watch_b` differs from its value at the previous tick and `guard` is 1, `release_o` is 1 in the following clock cycle.
- R4: A change on either bus at a tick where `guard` is 0 does not release, and the timeout count keeps advancing.
- R5: A cycle with `tick` low never releases and updates no state. A bus that changes and returns to its old value between two ticks gives no change event.
- R6: With `timeout` = T > 0, `release_o` pulses after the tick at which the count of ticks since the last release, including that tick, reaches or exceeds T. The count starts from 0 at reset, so without events the releases come at ticks T, 2T, 3T and so on after reset.
- R7: Every release, whether caused by an event or by the timeout, restarts the tick count at zero.
- R8: With `timeout` = 0, ticks without a start condition never release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Marks the clock cycles that are time steps |
| watch_a | input | WATCH_W | First watched bus |
| watch_b | input | WATCH_W | Second watched bus |
| guard | input | 1 | Condition that must be true for a change to release |
| timeout | input | 16 | Ticks before a timeout release; 0 disables |
| release_o | output | 1 | One-cycle release pulse, registered |

## Verification
The hardest case to reach is a timeout release that has to be traced back to the right restart point. That happens when an event-driven release, guarded-off changes and non-tick cycles all fall inside one timeout window. The stimulus puts event releases part-way through windows, inserts idle cycles and guard-low changes between ticks, and lowers `timeout` below the running count. A reference model in the bench counts ticks on its own, so a miscounted restart shows up as a pulse on the wrong cycle. A change that is undone between ticks is also driven, to show that only values at ticks are compared.

// File: rtl/wait_release_pkg.sv
// Shared types for the wait condition release evaluator.
// Assumes the timeout input and the tick counter share one width.
package wait_release_pkg;
    localparam int unsigned CNT_W = 16;
    typedef logic [CNT_W-1:0] tick_cnt_t;

    // Reason a release is issued at a tick.
    typedef struct packed {
        logic by_event;
        logic by_timeout;
    } rel_cause_t;
endpackage

// File: rtl/wre_change_det.sv
// Change detector for one watched bus.
// Compares the bus with its value at the previous tick. The held value
// loads the live bus during reset, so the first tick sees no false change.
// Assumes tick marks the only cycles where comparison is meaningful.
module wre_change_det #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] bus,
    output logic         changed
);
    logic [W-1:0] held;

    // Capture the bus value at reset and at each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            held <= bus;
        else if (tick)
            held <= bus;
    end

    // Flag a difference from the previous tick value.
    always_comb changed = tick && (bus != held);

    // R5: the held value only moves on ticks.
    a_r5_hold_off_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(held));
endmodule

// File: rtl/wre_timeout_ctr.sv
// Tick counter for the timeout path.
// Counts ticks since the last release and raises fire once the count,
// including the current tick, reaches the timeout. Restarts on any
// release. A timeout of zero never fires. Saturates rather than wrapping.
module wre_timeout_ctr
    import wait_release_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      restart,
    input  tick_cnt_t limit,
    output logic      fire
);
    localparam tick_cnt_t CNT_MAX = '1;

    tick_cnt_t         cnt;
    logic [CNT_W:0]    cnt_next_wide;

    // Count including the current tick, one bit wider for the compare.
    always_comb cnt_next_wide = {1'b0, cnt} + 1'b1;

    // Timeout reached at this tick when enabled.
    always_comb fire = tick && (limit != '0) &&
                       (cnt_next_wide >= {1'b0, limit});

    // Advance on ticks, restart on release, saturate at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (tick) begin
            if (restart || fire)
                cnt <= '0;
            else if (cnt != CNT_MAX)
                cnt <= cnt_next_wide[CNT_W-1:0];
        end
    end

    // R8: a zero limit never fires.
    a_r8_zero_disables: assert property (@(posedge clk) disable iff (!rst_n)
        (limit == '0) |-> !fire);
    // R7: a restarting tick clears the count.
    a_r7_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && restart) |=> (cnt == '0));
    // R5: no tick leaves the count alone.
    a_r5_cnt_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));
endmodule

// File: rtl/wait_release_eval.sv
// Wait condition release evaluator, top level.
// Releases a suspended process when either watched bus changes at a tick
// while guard is true, or after a programmable number of ticks with no
// release. The output is registered: it pulses the cycle after the
// deciding tick. Assumes inputs are synchronous to clk.
module wait_release_eval
    import wait_release_pkg::*;
#(
    parameter int unsigned WATCH_W   = 8,
    parameter int unsigned NUM_WATCH = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic [WATCH_W-1:0] watch_a,
    input  logic [WATCH_W-1:0] watch_b,
    input  logic               guard,
    input  logic [15:0]        timeout,
    output logic               release_o
);
    logic [WATCH_W-1:0]   watch_bus [NUM_WATCH];
    logic [NUM_WATCH-1:0] chg;
    logic                 start;
    logic                 fire;
    rel_cause_t           cause;

    // Gather watched buses into one array.
    always_comb begin
        watch_bus[0] = watch_a;
        watch_bus[1] = watch_b;
    end

    // One change detector per watched bus.
    for (genvar i = 0; i < NUM_WATCH; i++) begin : g_det
        wre_change_det #(.W(WATCH_W)) u_det (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .bus     (watch_bus[i]),
            .changed (chg[i])
        );
    end

    // Start condition: any change while guarded true.
    always_comb start = (|chg) && guard;

    wre_timeout_ctr u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .restart (start),
        .limit   (tick_cnt_t'(timeout)),
        .fire    (fire)
    );

    // Collect release causes for this tick.
    always_comb begin
        cause.by_event   = start;
        cause.by_timeout = fire;
    end

    // Register the release pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            release_o <= 1'b0;
        else
            release_o <= tick && (cause.by_event || cause.by_timeout);
    end

    // R1: first cycle after reset has no pulse.
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> !release_o);
    // R5: no tick, no pulse.
    a_r5_no_tick_no_release: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> !release_o);
    // R4: guard low with no timeout gives no pulse.
    a_r4_guard_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !guard && !fire) |=> !release_o);
    // R2: a change on the first bus with guard high releases.
    a_r2_event_a: assert property (@(posedge clk) disable iff (!rst_n)
        (chg[0] && guard) |=> release_o);
    // R3: a change on the second bus with guard high releases.
    a_r3_event_b: assert property (@(posedge clk) disable iff (!rst_n)
        (chg[1] && guard) |=> release_o);
    // R6: a timeout firing releases.
    a_r6_timeout_release: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> release_o);
endmodule

// File: tb/sim_wait_release_eval.sv
module sim_wait_release_eval;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [7:0]  watch_a = 8'h00;
    logic [7:0]  watch_b = 8'h00;
    logic        guard = 1'b0;
    logic [15:0] timeout = 16'd0;
    logic        release_o;

    always #4 clk = ~clk;

    wait_release_eval u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .watch_a(watch_a),
        .watch_b(watch_b), .guard(guard), .timeout(timeout),
        .release_o(release_o)
    );

    typedef struct {
        logic  exp;
        string tag;
    } item_t;

    item_t q[$];
    int    n_run = 0;
    int    n_fail = 0;
    bit    finished = 0;

    // Reference model state
    logic [7:0] m_pa, m_pb;
    int         m_cnt;

    task automatic step(input bit rn, input bit tk, input logic [7:0] a,
                        input logic [7:0] b, input bit g,
                        input logic [15:0] to, input string tag);
        item_t it;
        bit st, fi;
        @(negedge clk);
        rst_n = rn; tick = tk; watch_a = a; watch_b = b; guard = g;
        timeout = to;
        it.tag = tag;
        if (!rn) begin
            m_pa = a; m_pb = b; m_cnt = 0; it.exp = 1'b0;
        end else if (tk) begin
            st = ((a != m_pa) || (b != m_pb)) && g;
            fi = (to != 0) && (m_cnt + 1 >= int'(to));
            it.exp = st || fi;
            if (st || fi) m_cnt = 0;
            else if (m_cnt < 65535) m_cnt = m_cnt + 1;
            m_pa = a; m_pb = b;
        end else begin
            it.exp = 1'b0;
        end
        q.push_back(it);
    endtask

    // Monitor: compare each produced result with its queued expectation.
    always @(posedge clk) begin
        item_t it;
        #2;
        if (q.size() > 0) begin
            it = q.pop_front();
            n_run++;
            if (release_o !== it.exp) begin
                n_fail++;
                $display("FAIL %s: release_o=%b expected=%b at %0t",
                         it.tag, release_o, it.exp, $time);
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: expired, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset with nonzero buses, then first tick unchanged
        for (int i = 0; i < 3; i++) step(0, 1, 8'h5A, 8'hC3, 1, 0, "R1");
        step(1, 1, 8'h5A, 8'hC3, 1, 0, "R1");
        step(1, 1, 8'h5A, 8'hC3, 1, 0, "R1");
        // R2: change on first bus, guard high
        step(1, 1, 8'h5B, 8'hC3, 1, 0, "R2");
        step(1, 1, 8'h5B, 8'hC3, 1, 0, "R2");
        // R3: change on second bus, then both
        step(1, 1, 8'h5B, 8'h00, 1, 0, "R3");
        step(1, 1, 8'hFF, 8'h01, 1, 0, "R3");
        // R4: changes with guard low
        step(1, 1, 8'h10, 8'h01, 0, 0, "R4");
        step(1, 1, 8'h10, 8'h77, 0, 0, "R4");
        // R5: change with no tick, then undone before the tick
        step(1, 0, 8'h20, 8'h77, 1, 0, "R5");
        step(1, 0, 8'h10, 8'h77, 1, 0, "R5");
        step(1, 1, 8'h10, 8'h77, 1, 0, "R5");
        // R5: change held over idle cycles is seen at next tick
        step(1, 0, 8'h30, 8'h77, 1, 0, "R5");
        step(1, 1, 8'h30, 8'h77, 1, 0, "R5");
        // R6: timeout 4, pulses every 4th tick, idle cycles between
        for (int i = 0; i < 10; i++) begin
            step(1, 1, 8'h30, 8'h77, 1, 4, "R6");
            if (i % 3 == 1) step(1, 0, 8'h30, 8'h77, 1, 4, "R6");
        end
        // R7: event mid-window restarts the count
        step(1, 1, 8'h31, 8'h77, 1, 4, "R7");
        for (int i = 0; i < 5; i++) step(1, 1, 8'h31, 8'h77, 1, 4, "R7");
        // R4: guard-low change does not restart the count
        step(1, 1, 8'h31, 8'h78, 0, 4, "R4");
        for (int i = 0; i < 4; i++) step(1, 1, 8'h31, 8'h78, 0, 4, "R4");
        // R6: timeout lowered below the running count
        step(1, 1, 8'h31, 8'h78, 0, 9, "R6");
        step(1, 1, 8'h31, 8'h78, 0, 9, "R6");
        step(1, 1, 8'h31, 8'h78, 0, 9, "R6");
        step(1, 1, 8'h31, 8'h78, 0, 2, "R6");
        step(1, 1, 8'h31, 8'h78, 0, 2, "R6");
        // R8: zero timeout, many ticks, no pulses
        for (int i = 0; i < 20; i++) step(1, 1, 8'h31, 8'h78, 0, 0, "R8");
        // R1, R6: reset again, window restarts from reset
        step(0, 1, 8'h00, 8'h00, 0, 3, "R1");
        step(0, 1, 8'h00, 8'h00, 0, 3, "R1");
        for (int i = 0; i < 7; i++) step(1, 1, 8'h00, 8'h00, 0, 3, "R6");
        // Long timeout with an event at the edge of the window
        for (int i = 0; i < 40; i++)
            step(1, 1, (i == 20) ? 8'h01 : 8'h00, 8'h00, 1, 25, "R7");
        step(1, 0, 8'h00, 8'h00, 0, 0, "R5");
        step(1, 0, 8'h00, 8'h00, 0, 0, "R5");
        @(negedge clk);
        @(negedge clk);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule